// File: doc/BRIEF.md
# Interleaved Burst Protocol Monitor

This block watches the transmit side of an eight-word-wide user interface. On that interface packets are cut into bursts, and bursts from different channels may alternate. The monitor never drives the bus. Every clock it samples the control fields: packet-start, burst-start, burst-end, the channel number, the count of valid words and the 4-bit packet-end code. From these it keeps two kinds of state. The first is the single burst in flight and the channel that burst belongs to. The second is one open-packet flag and one byte accumulator for each tracked channel.

Each protocol violation sets a bit in a sticky error vector and raises a one-cycle error strobe. A packet that closes correctly produces a one-cycle done strobe, together with its channel number and its total byte count. Two free-running counters record the completed packets and the idle cycles. All outputs are registered. Anything caused by an input cycle appears one clock after that cycle.

Top module: `ilv_burst_monitor`

## Requirements
- R1: A cycle with a valid-word count of zero is idle. In an idle cycle every other control field is ignored: no error, no done strobe and no change to burst or packet state. `idle_count` increments by one.
- R2: A non-idle cycle with a valid-word count above eight sets error bit 0. Valid words are packed toward the top of the bus, so a count of 1 to 8 fully describes the cycle.
- R3: The channel field is checked only in non-idle cycles that assert burst-start or packet-start. A value of `NUM_CH` or more sets error bit 1, and the burst is then not tracked. In other cycles the channel field has no effect.
- R4: Packet-start without burst-start in a non-idle cycle sets error bit 2.
- R5: Burst-start while a burst is still open sets error bit 3, and the new burst replaces the old one. A non-idle cycle with no open burst and no burst-start sets error bit 4.
- R6: Packet state is kept per channel, so bursts of different channels may interleave. Packet-start on a channel that already has an open packet sets error bit 5. Burst-start without packet-start on a channel with no open packet sets error bit 6.
- R7: The packet-end code is 4 bits. Zero means the packet continues. Bit 3 set means the cycle holds the packet's last word, and bits 2:0 give the bytes valid in that word, where 0 means all 8. A nonzero code in a cycle without burst-end, or a nonzero code with bit 3 clear, sets error bit 7 in a non-idle cycle.
- R8: In a cycle with burst-end and a code with bit 3 set, the packet of the current channel closes. One cycle later `pkt_done` pulses with `done_chan` and `done_bytes`. The byte total is 8 bytes per valid word, summed over every cycle of the packet, except that the last word counts only the bytes the code gives.
- R9: `err_sticky` holds the OR of all error bits seen since reset. `err_pulse` is high for exactly the cycle after each violating cycle.
- R10: `pkt_count` increments by one with every `pkt_done` pulse.
- R11: Reset clears all outputs, the burst state and every channel's packet state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_sop | input | 1 | Packet-start |
| in_sob | input | 1 | Burst-start |
| in_eob | input | 1 | Burst-end |
| in_chan | input | 8 | Channel number |
| in_nvalid | input | 4 | Count of valid words, 0 means idle |
| in_eop | input | 4 | Packet-end code |
| err_sticky | output | 8 | Accumulated error bits |
| err_pulse | output | 1 | Violation seen in the previous cycle |
| pkt_done | output | 1 | Packet closed in the previous cycle |
| done_chan | output | 8 | Channel of the closed packet |
| done_bytes | output | BYTE_W | Byte count of the closed packet |
| pkt_count | output | CNT_W | Completed packets |
| idle_count | output | CNT_W | Idle cycles |

## Verification
The bench builds the monitor with `NUM_CH` set to 4. With that value, channel number 5 is out of range, so the range error can be reached with small stimulus, while channels 0 to 3 still let three or four packets interleave. It uses `BYTE_W` 16 and `CNT_W` 16, so no byte total or counter wraps during the run and every expected total is exact. Under these values one vector walk can reach every error bit, packets that span interleaved bursts, and the all-bytes encoding of the final word.

// File: rtl/ilv_mon_pkg.sv
package ilv_mon_pkg;

    localparam int CHAN_W     = 8;
    localparam int NV_W       = 4;
    localparam int EOP_W      = 4;
    localparam int BUS_WORDS  = 8;
    localparam int WORD_BYTES = 8;
    localparam int NUM_ERR    = 8;

    // error bit positions
    localparam int E_COUNT    = 0;
    localparam int E_CHAN     = 1;
    localparam int E_SOP_ALONE = 2;
    localparam int E_SOB_OPEN = 3;
    localparam int E_NO_BURST = 4;
    localparam int E_SOP_DUP  = 5;
    localparam int E_CONT     = 6;
    localparam int E_EOP_FORM = 7;

    typedef struct packed {
        logic              sop;
        logic              sob;
        logic              eob;
        logic [CHAN_W-1:0] chan;
        logic [NV_W-1:0]   nvalid;
        logic [EOP_W-1:0]  eop;
    } beat_t;

    typedef logic [NUM_ERR-1:0] err_vec_t;

    // bytes held by the last word of a packet; a low field of zero means a full word
    function automatic logic [3:0] tail_bytes(input logic [2:0] low);
        return (low == 3'd0) ? 4'(WORD_BYTES) : {1'b0, low};
    endfunction

endpackage

// File: rtl/ilv_cycle_decode.sv
module ilv_cycle_decode
    import ilv_mon_pkg::*;
#(
    parameter int NUM_CH = 16
) (
    input  beat_t       beat,
    output logic        idle,
    output logic        is_end,
    output logic [7:0]  beat_bytes,
    output err_vec_t    fmt_err
);
    logic [7:0] nv8;
    logic [7:0] full_bytes;
    logic [7:0] last_bytes;

    always_comb begin
        nv8        = {4'b0, beat.nvalid};
        idle       = (beat.nvalid == '0);
        is_end     = !idle && beat.eob && beat.eop[EOP_W-1];
        full_bytes = nv8 << 3;
        last_bytes = ((nv8 - 8'd1) << 3) + {4'b0, tail_bytes(beat.eop[2:0])};
        beat_bytes = is_end ? last_bytes : full_bytes;

        fmt_err             = '0;
        fmt_err[E_COUNT]    = !idle && (nv8 > 8'(BUS_WORDS));
        fmt_err[E_CHAN]     = !idle && (beat.sop || beat.sob) &&
                              ({1'b0, beat.chan} >= 9'(NUM_CH));
        fmt_err[E_SOP_ALONE] = !idle && beat.sop && !beat.sob;
        fmt_err[E_EOP_FORM] = !idle && (beat.eop != '0) &&
                              (!beat.eob || !beat.eop[EOP_W-1]);
    end

endmodule

// File: rtl/ilv_burst_tracker.sv
module ilv_burst_tracker
    import ilv_mon_pkg::*;
#(
    parameter int NUM_CH = 16,
    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  beat_t            beat,
    input  logic             idle,
    output logic             active,
    output logic [IDX_W-1:0] act_ch,
    output logic             err_sob_open,
    output logic             err_no_burst
);
    logic             open_q;
    logic             ok_q;
    logic [IDX_W-1:0] ch_q;
    logic             in_range;

    always_comb begin
        in_range     = ({1'b0, beat.chan} < 9'(NUM_CH));
        active       = 1'b0;
        act_ch       = ch_q;
        err_sob_open = 1'b0;
        err_no_burst = 1'b0;
        if (!idle) begin
            if (beat.sob) begin
                active       = in_range;
                act_ch       = beat.chan[IDX_W-1:0];
                err_sob_open = open_q;
            end else if (open_q) begin
                active = ok_q;
            end else begin
                err_no_burst = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
            ok_q   <= 1'b0;
            ch_q   <= '0;
        end else if (!idle) begin
            if (beat.sob) begin
                open_q <= !beat.eob;
                ok_q   <= in_range;
                ch_q   <= beat.chan[IDX_W-1:0];
            end else if (open_q && beat.eob) begin
                open_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/ilv_chan_table.sv
module ilv_chan_table
    import ilv_mon_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int BYTE_W = 16,
    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic [IDX_W-1:0]  act_ch,
    input  logic              sop,
    input  logic              sob,
    input  logic              is_end,
    input  logic [7:0]        beat_bytes,
    output logic              err_dup,
    output logic              err_cont,
    output logic              done,
    output logic [BYTE_W-1:0] done_bytes
);
    logic [NUM_CH-1:0] open_q;
    logic [BYTE_W-1:0] acc_q [NUM_CH];
    logic              cur_open;
    logic [BYTE_W-1:0] total;

    always_comb begin
        cur_open   = open_q[act_ch];
        total      = (sop ? '0 : acc_q[act_ch]) + BYTE_W'(beat_bytes);
        err_dup    = active && sop && cur_open;
        err_cont   = active && sob && !sop && !cur_open;
        done       = active && is_end && (cur_open || sop);
        done_bytes = total;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst) begin
                open_q[c] <= 1'b0;
                acc_q[c]  <= '0;
            end else if (active && (act_ch == IDX_W'(c))) begin
                if (is_end) begin
                    open_q[c] <= 1'b0;
                    acc_q[c]  <= '0;
                end else begin
                    if (sop) open_q[c] <= 1'b1;
                    acc_q[c] <= total;
                end
            end
        end
    end

endmodule

// File: rtl/ilv_burst_monitor.sv
module ilv_burst_monitor
    import ilv_mon_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int BYTE_W = 16,
    parameter int CNT_W  = 16,
    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_sop,
    input  logic              in_sob,
    input  logic              in_eob,
    input  logic [7:0]        in_chan,
    input  logic [3:0]        in_nvalid,
    input  logic [3:0]        in_eop,
    output logic [7:0]        err_sticky,
    output logic              err_pulse,
    output logic              pkt_done,
    output logic [7:0]        done_chan,
    output logic [BYTE_W-1:0] done_bytes,
    output logic [CNT_W-1:0]  pkt_count,
    output logic [CNT_W-1:0]  idle_count
);
    beat_t             beat;
    logic              idle;
    logic              is_end;
    logic [7:0]        beat_bytes;
    err_vec_t          fmt_err;
    logic              active;
    logic [IDX_W-1:0]  act_ch;
    logic              err_sob_open;
    logic              err_no_burst;
    logic              err_dup;
    logic              err_cont;
    logic              done_now;
    logic [BYTE_W-1:0] bytes_now;
    err_vec_t          err_now;

    always_comb begin
        beat.sop    = in_sop;
        beat.sob    = in_sob;
        beat.eob    = in_eob;
        beat.chan   = in_chan;
        beat.nvalid = in_nvalid;
        beat.eop    = in_eop;
    end

    ilv_cycle_decode #(.NUM_CH(NUM_CH)) u_decode (
        .beat       (beat),
        .idle       (idle),
        .is_end     (is_end),
        .beat_bytes (beat_bytes),
        .fmt_err    (fmt_err)
    );

    ilv_burst_tracker #(.NUM_CH(NUM_CH)) u_burst (
        .clk          (clk),
        .rst          (rst),
        .beat         (beat),
        .idle         (idle),
        .active       (active),
        .act_ch       (act_ch),
        .err_sob_open (err_sob_open),
        .err_no_burst (err_no_burst)
    );

    ilv_chan_table #(.NUM_CH(NUM_CH), .BYTE_W(BYTE_W)) u_table (
        .clk        (clk),
        .rst        (rst),
        .active     (active),
        .act_ch     (act_ch),
        .sop        (in_sop),
        .sob        (in_sob),
        .is_end     (is_end),
        .beat_bytes (beat_bytes),
        .err_dup    (err_dup),
        .err_cont   (err_cont),
        .done       (done_now),
        .done_bytes (bytes_now)
    );

    always_comb begin
        err_now             = fmt_err;
        err_now[E_SOB_OPEN] = err_sob_open;
        err_now[E_NO_BURST] = err_no_burst;
        err_now[E_SOP_DUP]  = err_dup;
        err_now[E_CONT]     = err_cont;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_sticky <= '0;
            err_pulse  <= 1'b0;
            pkt_done   <= 1'b0;
            done_chan  <= '0;
            done_bytes <= '0;
            pkt_count  <= '0;
            idle_count <= '0;
        end else begin
            err_sticky <= err_sticky | err_now;
            err_pulse  <= |err_now;
            pkt_done   <= done_now;
            if (done_now) begin
                done_chan  <= 8'(act_ch);
                done_bytes <= bytes_now;
                pkt_count  <= pkt_count + 1'b1;
            end
            if (idle) idle_count <= idle_count + 1'b1;
        end
    end

endmodule

// File: rtl/ilv_burst_monitor_chk.sv
module ilv_burst_monitor_chk #(
    parameter int NUM_CH = 16,
    parameter int CNT_W  = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             in_eob,
    input logic [3:0]       in_nvalid,
    input logic [3:0]       in_eop,
    input logic [7:0]       err_sticky,
    input logic             err_pulse,
    input logic             pkt_done,
    input logic [7:0]       done_chan,
    input logic [CNT_W-1:0] pkt_count,
    input logic [CNT_W-1:0] idle_count
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        (in_nvalid == 4'd0) |=> (!err_pulse && !pkt_done));

    assert_idle_count_R1: assert property (@(posedge clk) disable iff (rst)
        (in_nvalid == 4'd0) |=> (idle_count == CNT_W'($past(idle_count) + 1'b1)));

    assert_over_count_R2: assert property (@(posedge clk) disable iff (rst)
        (in_nvalid > 4'd8) |=> (err_pulse && err_sticky[0]));

    assert_eop_form_R7: assert property (@(posedge clk) disable iff (rst)
        ((in_nvalid != 4'd0) && (in_eop != 4'd0) && !in_eob) |=> err_sticky[7]);

    assert_done_chan_R8: assert property (@(posedge clk) disable iff (rst)
        pkt_done |-> ({1'b0, done_chan} < 9'(NUM_CH)));

    assert_sticky_keeps_R9: assert property (@(posedge clk) disable iff (rst)
        (err_sticky & $past(err_sticky)) == $past(err_sticky));

    assert_pulse_sets_R9: assert property (@(posedge clk) disable iff (rst)
        err_pulse |-> (err_sticky != 8'd0));

    assert_pkt_count_R10: assert property (@(posedge clk) disable iff (rst)
        pkt_done |-> (pkt_count == CNT_W'($past(pkt_count) + 1'b1)));

endmodule

bind ilv_burst_monitor ilv_burst_monitor_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_eob     (in_eob),
    .in_nvalid  (in_nvalid),
    .in_eop     (in_eop),
    .err_sticky (err_sticky),
    .err_pulse  (err_pulse),
    .pkt_done   (pkt_done),
    .done_chan  (done_chan),
    .pkt_count  (pkt_count),
    .idle_count (idle_count)
);

// File: tb/ilv_burst_monitor_tb.sv
module ilv_burst_monitor_tb;

    localparam int NUM_CH = 4;
    localparam int BYTE_W = 16;
    localparam int CNT_W  = 16;

    typedef struct packed {
        logic [3:0]  req;
        logic        sop;
        logic        sob;
        logic        eob;
        logic [7:0]  chan;
        logic [3:0]  nv;
        logic [3:0]  eop;
        logic [7:0]  exp_err;
        logic        exp_done;
        logic [7:0]  exp_ch;
        logic [15:0] exp_bytes;
    } vec_t;

    localparam int NVEC = 19;
    localparam vec_t TBL [NVEC] = '{
        // R6: channel 2 opens a packet with a full cycle
        '{4'd6, 1'b1, 1'b1, 1'b0, 8'd2,   4'd8, 4'h0, 8'h00, 1'b0, 8'd0, 16'd0},
        // R3: channel field is junk mid-burst and is not checked
        '{4'd3, 1'b0, 1'b0, 1'b1, 8'hFF,  4'd8, 4'h0, 8'h00, 1'b0, 8'd0, 16'd0},
        // R8: short one-cycle packet on channel 3, 2 full words + 3 bytes
        '{4'd8, 1'b1, 1'b1, 1'b1, 8'd3,   4'd3, 4'hB, 8'h00, 1'b1, 8'd3, 16'd19},
        // R1: idle cycle with garbage controls
        '{4'd1, 1'b1, 1'b1, 1'b0, 8'hEE,  4'd0, 4'hF, 8'h00, 1'b0, 8'd0, 16'd0},
        // R6: continuation burst of channel 2
        '{4'd6, 1'b0, 1'b1, 1'b1, 8'd2,   4'd8, 4'h0, 8'h00, 1'b0, 8'd0, 16'd0},
        // R8: low bits zero mean a full final word
        '{4'd8, 1'b1, 1'b1, 1'b1, 8'd1,   4'd8, 4'h8, 8'h00, 1'b1, 8'd1, 16'd64},
        '{4'd6, 1'b1, 1'b1, 1'b0, 8'd0,   4'd8, 4'h0, 8'h00, 1'b0, 8'd0, 16'd0},
        // R8: two-cycle packet on channel 0
        '{4'd8, 1'b0, 1'b0, 1'b1, 8'd7,   4'd2, 4'hB, 8'h00, 1'b1, 8'd0, 16'd75},
        // R8: channel 2 closes after interleaving
        '{4'd8, 1'b0, 1'b1, 1'b1, 8'd2,   4'd1, 4'h8, 8'h00, 1'b1, 8'd2, 16'd200},
        // R6: continuation on a closed channel -> bit 6
        '{4'd6, 1'b0, 1'b1, 1'b0, 8'd2,   4'd8, 4'h0, 8'h40, 1'b0, 8'd0, 16'd0},
        // R5: burst start while a burst is open -> bit 3
        '{4'd5, 1'b1, 1'b1, 1'b0, 8'd1,   4'd4, 4'h0, 8'h08, 1'b0, 8'd0, 16'd0},
        // R2: valid count 9 -> bit 0
        '{4'd2, 1'b0, 1'b0, 1'b1, 8'd0,   4'd9, 4'h0, 8'h01, 1'b0, 8'd0, 16'd0},
        // R5: data with no open burst -> bit 4
        '{4'd5, 1'b0, 1'b0, 1'b0, 8'd0,   4'd8, 4'h0, 8'h10, 1'b0, 8'd0, 16'd0},
        // R3: channel 5 out of range -> bit 1
        '{4'd3, 1'b1, 1'b1, 1'b0, 8'd5,   4'd8, 4'h0, 8'h02, 1'b0, 8'd0, 16'd0},
        // R7: code with top bit clear -> bit 7, untracked burst gives no done
        '{4'd7, 1'b0, 1'b0, 1'b1, 8'd0,   4'd8, 4'h3, 8'h80, 1'b0, 8'd0, 16'd0},
        // R4: packet start without burst start -> bits 2 and 4
        '{4'd4, 1'b1, 1'b0, 1'b0, 8'd0,   4'd4, 4'h0, 8'h14, 1'b0, 8'd0, 16'd0},
        // R6: second packet start on open channel 1 -> bit 5
        '{4'd6, 1'b1, 1'b1, 1'b1, 8'd1,   4'd8, 4'h0, 8'h20, 1'b0, 8'd0, 16'd0},
        // R7: end code without burst end -> bit 7
        '{4'd7, 1'b1, 1'b1, 1'b0, 8'd0,   4'd8, 4'h8, 8'h80, 1'b0, 8'd0, 16'd0},
        // R8: packet on channel 0 still closes on the next end
        '{4'd8, 1'b0, 1'b0, 1'b1, 8'd9,   4'd1, 4'h8, 8'h00, 1'b1, 8'd0, 16'd72}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_sop = 1'b0;
    logic              in_sob = 1'b0;
    logic              in_eob = 1'b0;
    logic [7:0]        in_chan = '0;
    logic [3:0]        in_nvalid = '0;
    logic [3:0]        in_eop = '0;
    logic [7:0]        err_sticky;
    logic              err_pulse;
    logic              pkt_done;
    logic [7:0]        done_chan;
    logic [BYTE_W-1:0] done_bytes;
    logic [CNT_W-1:0]  pkt_count;
    logic [CNT_W-1:0]  idle_count;

    int checks = 0;
    int fails  = 0;
    logic [7:0] exp_sticky = '0;

    always #10 clk = ~clk;

    ilv_burst_monitor #(.NUM_CH(NUM_CH), .BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .in_sop     (in_sop),
        .in_sob     (in_sob),
        .in_eob     (in_eob),
        .in_chan    (in_chan),
        .in_nvalid  (in_nvalid),
        .in_eop     (in_eop),
        .err_sticky (err_sticky),
        .err_pulse  (err_pulse),
        .pkt_done   (pkt_done),
        .done_chan  (done_chan),
        .done_bytes (done_bytes),
        .pkt_count  (pkt_count),
        .idle_count (idle_count)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic put(input logic sop, input logic sob, input logic eob,
                       input logic [7:0] ch, input logic [3:0] nv, input logic [3:0] eop);
        in_sop = sop; in_sob = sob; in_eob = eob;
        in_chan = ch; in_nvalid = nv; in_eop = eop;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R11: reset state
        chk("R11", "sticky", 32'(err_sticky), 32'd0);
        chk("R11", "done",   32'(pkt_done), 32'd0);
        chk("R11", "pkts",   32'(pkt_count), 32'd0);

        for (int i = 0; i < NVEC; i++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", TBL[i].req, i);
            put(TBL[i].sop, TBL[i].sob, TBL[i].eob, TBL[i].chan, TBL[i].nv, TBL[i].eop);
            @(negedge clk);
            exp_sticky |= TBL[i].exp_err;
            chk(tag, "err_pulse", 32'(err_pulse), 32'(TBL[i].exp_err != 8'd0));
            chk(tag, "sticky", 32'(err_sticky), 32'(exp_sticky));
            chk(tag, "pkt_done", 32'(pkt_done), 32'(TBL[i].exp_done));
            if (TBL[i].exp_done) begin
                chk(tag, "done_chan", 32'(done_chan), 32'(TBL[i].exp_ch));
                chk(tag, "done_bytes", 32'(done_bytes), 32'(TBL[i].exp_bytes));
            end
        end
        put(1'b0, 1'b0, 1'b0, 8'd0, 4'd0, 4'd0);
        @(negedge clk);
        chk("R9", "sticky all", 32'(err_sticky), 32'hFF);
        chk("R9", "pulse drops", 32'(err_pulse), 32'd0);
        chk("R10", "pkt_count", 32'(pkt_count), 32'd5);
        chk("R1", "idle_count", 32'(idle_count), 32'd2);

        // R11: reset clears sticky state and counters
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R11", "sticky after rst", 32'(err_sticky), 32'd0);
        chk("R11", "idle after rst", 32'(idle_count), 32'd0);
        chk("R11", "pkts after rst", 32'(pkt_count), 32'd0);

        // R1: idle cycle inside a burst leaves the burst intact
        put(1'b1, 1'b1, 1'b0, 8'd3, 4'd8, 4'h0);
        @(negedge clk);
        put(1'b0, 1'b1, 1'b1, 8'd0, 4'd0, 4'hB);
        @(negedge clk);
        chk("R1", "idle no error", 32'(err_pulse), 32'd0);
        chk("R1", "idle counted", 32'(idle_count), 32'd1);
        put(1'b0, 1'b0, 1'b1, 8'd0, 4'd4, 4'hA);
        @(negedge clk);
        chk("R8", "done after idle", 32'(pkt_done), 32'd1);
        chk("R8", "chan after idle", 32'(done_chan), 32'd3);
        chk("R8", "bytes after idle", 32'(done_bytes), 32'd90);
        chk("R9", "clean run", 32'(err_sticky), 32'd0);
        put(1'b0, 1'b0, 1'b0, 8'd0, 4'd0, 4'd0);
        @(negedge clk);
        chk("R8", "done is one cycle", 32'(pkt_done), 32'd0);
        chk("R10", "count after rst", 32'(pkt_count), 32'd1);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule